// File: doc/BRIEF.md
# Buffered UART Transmitter with Single and FIFO Modes

This block is the transmit half of an asynchronous serial port. A host writes bytes through a single write strobe. The bytes are placed in a buffer, moved one at a time into a frame shifter, and sent on a line that idles high. Each frame has a low start bit, seven or eight data bits and a high stop bit. The line advances by one bit on each pulse of an external baud tick. The data can go out least-significant bit first or most-significant bit first. In seven-bit frames the bits are taken from opposite ends of the byte depending on that order.

The buffer works in one of two modes. In single mode it is a one-byte holding register. A write made while transmit enable is high starts a frame as soon as the shifter is free. In FIFO mode it is a sixteen-entry queue with a four-bit trigger level. Sending begins only once transmit enable is high and the queue holds at least the trigger count. After that the queue drains until it is empty.

Two one-cycle interrupt pulses report progress. The transmit interrupt fires when buffer space is freed. In single mode that is every byte handed to the shifter. In FIFO mode it is every trigger count of bytes handed to the shifter. The empty interrupt fires in FIFO mode when the last frame has finished and nothing remains queued. Writes that find the buffer full are dropped and set a sticky overflow flag. Configuration inputs are expected to be stable while data is buffered or a frame is in flight.

Top module: `uart_tx_buf`

## Requirements
- R1: After reset, tx_o is 1, tx_int_o and empty_int_o are 0, overflow_o is 0 and the buffer is empty.
- R2: A frame is a start bit of 0, then the data bits, then a stop bit of 1. tx_o goes to 0 in the cycle after a byte enters the shifter. It moves to the next bit after each clock edge at which baud_tick_i is high. The shifter is free again after the tick that ends the stop bit. tx_o is 1 whenever no frame is in flight.
- R3: With len7_i=0, eight data bits are sent: bits 0 to 7 when msb_first_i=0, bits 7 to 0 when msb_first_i=1. With len7_i=1, seven bits are sent: bits 0 to 6 when msb_first_i=0, bits 7 to 1 (bit 7 first) when msb_first_i=1.
- R4: In single mode (fifo_mode_i=0), the buffer holds one byte. That byte is moved into the shifter whenever tx_en_i is 1 and the shifter is free. A write that finds the holding register occupied, with no move into the shifter in that cycle, is dropped.
- R5: In single mode, tx_int_o is high for exactly one cycle, the cycle after each byte moves into the shifter.
- R6: In FIFO mode (fifo_mode_i=1), no byte moves into the shifter until tx_en_i is 1 and the queue holds at least the trigger count. The trigger count is trig_i, and a trig_i value of 0 means 16.
- R7: In FIFO mode, tx_int_o is high for one cycle after every trigger-count-th byte moved into the shifter since the burst started.
- R8: In FIFO mode, empty_int_o is high for one cycle, the cycle after a frame ends with the queue empty and no write accepted in that cycle. It never rises in single mode.
- R9: The FIFO holds 16 bytes. A write is accepted when the buffer is not full, or when a byte moves into the shifter in the same cycle. Otherwise the write is dropped and overflow_o becomes 1 and stays 1 until reset.
- R10: In FIFO mode, once a burst has started the queue keeps draining below the trigger count until it is empty. Dropping tx_en_i lets the current frame finish but stops further bytes from moving into the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | One-cycle pulse per bit period |
| tx_en_i | input | 1 | Transmit enable |
| fifo_mode_i | input | 1 | 0 single-byte holding register, 1 sixteen-entry FIFO |
| len7_i | input | 1 | 1 selects seven data bits, 0 eight |
| msb_first_i | input | 1 | 1 sends most-significant bit first |
| trig_i | input | 4 | FIFO trigger count, 0 means 16 |
| wr_i | input | 1 | Write strobe for wdata_i |
| wdata_i | input | 8 | Byte to transmit |
| tx_o | output | 1 | Serial line, idles high |
| tx_int_o | output | 1 | Transmit interrupt pulse |
| empty_int_o | output | 1 | FIFO and shifter empty pulse |
| overflow_o | output | 1 | Sticky dropped-write flag |

## Verification
Three pairs of events can land in the same cycle. A host write can coincide with the FIFO handing its head byte to the shifter while the FIFO is full; that write must be accepted, not dropped. The final stop-bit tick can coincide with a fresh write, and the empty pulse must then be held back. A baud tick can coincide with a byte load, and the load must win. The bench provokes these by holding the write strobe high for many cycles while a full queue drains, and by writing right around frame ends under a fixed tick cadence. It judges each cycle against a queue-based model for tx_o, both interrupts and overflow_o.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic {
    ORD_LSB = 1'b0,
    ORD_MSB = 1'b1
  } bit_order_e;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned FRAME_W = DATA_W + 2;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_one_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == (cap_one_i ? CW'(1) : CW'(DEPTH)));
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TW    = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic          fifo_mode_i,
  input  logic [TW-1:0] trig_i,
  input  logic [CW-1:0] count_i,
  input  logic          push_i,
  input  logic          busy_i,
  input  logic          done_i,
  output logic          load_o,
  output logic          tx_int_o,
  output logic          empty_int_o
);
  logic [CW-1:0] trig_eff;
  logic [CW-1:0] ld_cnt_q;
  logic          started_q;
  logic          ready;
  logic          empty_ev;
  logic          trig_hit;

  assign trig_eff = (trig_i == '0) ? CW'(DEPTH) : CW'(trig_i);

  // FIFO mode waits for the trigger level only before the burst starts
  assign ready  = fifo_mode_i ? (started_q || (count_i >= trig_eff)) : 1'b1;
  assign load_o = !busy_i && (count_i != '0) && tx_en_i && ready;

  assign empty_ev = fifo_mode_i && done_i && (count_i == '0) && !push_i;
  assign trig_hit = (ld_cnt_q + 1'b1) == trig_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q   <= 1'b0;
      ld_cnt_q    <= '0;
      tx_int_o    <= 1'b0;
      empty_int_o <= 1'b0;
    end else begin
      tx_int_o    <= load_o && (!fifo_mode_i || trig_hit);
      empty_int_o <= empty_ev;
      if (!tx_en_i || empty_ev) begin
        started_q <= 1'b0;
        ld_cnt_q  <= '0;
      end else if (load_o && fifo_mode_i) begin
        started_q <= 1'b1;
        ld_cnt_q  <= trig_hit ? '0 : ld_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic              len7_i,
  input  bit_order_e        order_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              tx_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W);

  logic [DATA_W-1:0]  seq;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   rem_q;
  logic               busy_q, tx_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_seq
    assign seq[i] = (order_i == ORD_MSB) ? data_i[DATA_W-1-i] : data_i[i];
  end

  // seven-bit frames keep the first seven sequence bits in either order
  assign frame = len7_i ? {2'b11, seq[DATA_W-2:0], 1'b0} : {1'b1, seq, 1'b0};

  assign done_o = busy_q && tick_i && (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      rem_q  <= '0;
      busy_q <= 1'b0;
      tx_q   <= 1'b1;
    end else if (load_i) begin
      sh_q   <= frame;
      rem_q  <= len7_i ? CNT_W'(DATA_W) : CNT_W'(DATA_W + 1);
      busy_q <= 1'b1;
      tx_q   <= frame[0];
    end else if (busy_q && tick_i) begin
      if (rem_q == '0) begin
        busy_q <= 1'b0;
        tx_q   <= 1'b1;
      end else begin
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        tx_q  <= sh_q[1];
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = tx_q;
endmodule

// File: rtl/uart_tx_buf.sv
module uart_tx_buf
  import uart_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TW    = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              tx_en_i,
  input  logic              fifo_mode_i,
  input  logic              len7_i,
  input  logic              msb_first_i,
  input  logic [TW-1:0]     trig_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              tx_o,
  output logic              tx_int_o,
  output logic              empty_int_o,
  output logic              overflow_o
);
  logic              load, accept, full, busy, done;
  logic [CW-1:0]     count;
  logic [DATA_W-1:0] head;
  logic              ovf_q;

  assign accept = wr_i && (!full || load);

  uart_tx_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_one_i (!fifo_mode_i),
    .push_i    (accept),
    .pop_i     (load),
    .wdata_i   (wdata_i),
    .rdata_o   (head),
    .count_o   (count),
    .full_o    (full)
  );

  uart_tx_ctrl #(.DEPTH(DEPTH), .TW(TW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_en_i     (tx_en_i),
    .fifo_mode_i (fifo_mode_i),
    .trig_i      (trig_i),
    .count_i     (count),
    .push_i      (accept),
    .busy_i      (busy),
    .done_i      (done),
    .load_o      (load),
    .tx_int_o    (tx_int_o),
    .empty_int_o (empty_int_o)
  );

  uart_tx_shifter u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .load_i  (load),
    .len7_i  (len7_i),
    .order_i (msb_first_i ? ORD_MSB : ORD_LSB),
    .data_i  (head),
    .busy_o  (busy),
    .done_o  (done),
    .tx_o    (tx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else if (wr_i && !accept) ovf_q <= 1'b1;
  end

  assign overflow_o = ovf_q;
endmodule

// File: rtl/uart_tx_buf_chk.sv
module uart_tx_buf_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_mode_i,
  input logic          tx_o,
  input logic          tx_int_o,
  input logic          empty_int_o,
  input logic          overflow_o,
  input logic          busy,
  input logic [CW-1:0] count
);
  assert_idle_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> tx_o);
  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !tx_o);
  assert_hold_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_mode_i |-> (count <= CW'(1)));
  assert_tx_int_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_int_o |=> !tx_int_o);
  assert_empty_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_int_o |=> !empty_int_o);
  assert_empty_fifo_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_int_o |-> $past(fifo_mode_i));
  assert_no_overrun_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH));
  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
endmodule

bind uart_tx_buf uart_tx_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_mode_i (fifo_mode_i),
  .tx_o        (tx_o),
  .tx_int_o    (tx_int_o),
  .empty_int_o (empty_int_o),
  .overflow_o  (overflow_o),
  .busy        (busy),
  .count       (count)
);

// File: tb/uart_tx_buf_bench.sv
`timescale 1ns/1ps
module uart_tx_buf_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, tx_en = 1'b0, fifo_mode = 1'b0, len7 = 1'b0, msb = 1'b0;
  logic [3:0] trig = 4'd0;
  logic wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic tx, tx_int, empty_int, ovf;

  int checks = 0, errors = 0, cycles = 0, tdiv = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  uart_tx_buf u_uart_tx_buf (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .tx_en_i(tx_en),
    .fifo_mode_i(fifo_mode), .len7_i(len7), .msb_first_i(msb), .trig_i(trig),
    .wr_i(wr), .wdata_i(wdata), .tx_o(tx), .tx_int_o(tx_int),
    .empty_int_o(empty_int), .overflow_o(ovf)
  );

  // behavioural reference
  byte unsigned q[$];
  bit bq[$];
  bit m_busy, m_tx, m_started, m_txint, m_empint, m_ovf;
  int m_ld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); bq.delete();
      m_busy = 0; m_tx = 1; m_started = 0; m_txint = 0; m_empint = 0; m_ovf = 0; m_ld = 0;
    end else begin
      int cap, te, nd;
      bit load, fin, acc, emp;
      byte unsigned d;
      cap = fifo_mode ? 16 : 1;
      te = (trig == 0) ? 16 : int'(trig);
      load = !m_busy && q.size() > 0 && tx_en && (!fifo_mode || m_started || q.size() >= te);
      fin = tick && m_busy && bq.size() == 0;
      acc = wr && (q.size() < cap || load);
      emp = fifo_mode && fin && q.size() == 0 && !acc;
      m_txint = load && (!fifo_mode || m_ld + 1 == te);
      m_empint = emp;
      if (wr && !acc) m_ovf = 1;
      if (!tx_en || emp) begin m_started = 0; m_ld = 0; end
      else if (load && fifo_mode) begin
        m_started = 1;
        m_ld = (m_ld + 1 == te) ? 0 : m_ld + 1;
      end
      if (load) begin
        d = q.pop_front();
        nd = len7 ? 7 : 8;
        for (int i = 0; i < nd; i++) bq.push_back(msb ? d[7-i] : d[i]);
        bq.push_back(1'b1);
        m_busy = 1; m_tx = 0;
      end else if (tick && m_busy) begin
        if (bq.size() == 0) begin m_busy = 0; m_tx = 1; end
        else m_tx = bq.pop_front();
      end
      if (acc) q.push_back(wdata);
    end
  end

  task automatic chk(bit cond, string req, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(tx == m_tx, "R2 R3 tx_o", tx, m_tx);
      chk(tx_int == m_txint, fifo_mode ? "R7 tx_int_o" : "R5 tx_int_o", tx_int, m_txint);
      chk(empty_int == m_empint, "R8 empty_int_o", empty_int, m_empint);
      chk(ovf == m_ovf, "R9 R4 overflow_o", ovf, m_ovf);
    end
    tdiv++;
    tick = (tdiv % 4 == 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done_flag) begin
      done_flag = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr = 0; tx_en = 0;
    repeat (3) @(negedge clk);
    chk(tx == 1 && tx_int == 0 && empty_int == 0 && ovf == 0, "R1 reset", {tx, tx_int, empty_int, ovf}, 4'b1000);
    rst_n = 1;
  endtask

  task automatic wr_byte(byte unsigned b);
    wr = 1; wdata = b;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin
      if (!m_busy && q.size() == 0) break;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    do_reset();
    // single mode, all four framings
    for (int cfg = 0; cfg < 4; cfg++) begin
      @(negedge clk);
      fifo_mode = 0; len7 = cfg[0]; msb = cfg[1]; tx_en = 1;
      wr_byte(8'hA5 ^ 8'(cfg * 8'h3C));
      @(negedge clk);
      chk(tx == 0, "R4 single start", tx, 0);
      wr_byte(8'h96);
      wr_byte(8'h3C);                // holding register busy: dropped
      chk(ovf == 1, "R4 R9 drop in single", ovf, 1);
      drain(400);
      do_reset();
    end
    // single mode write right around a frame end
    fifo_mode = 0; tx_en = 1; len7 = 0; msb = 0;
    for (int k = 0; k < 6; k++) begin
      wr_byte(8'(8'h11 * k + 1));
      repeat (36 + k) @(negedge clk);
    end
    drain(400);
    do_reset();
    // FIFO mode trigger 4
    @(negedge clk);
    fifo_mode = 1; trig = 4'd4; tx_en = 1; len7 = 0; msb = 1;
    for (int k = 0; k < 3; k++) wr_byte(8'(8'hC1 + k));
    repeat (60) @(negedge clk);
    chk(tx == 1, "R6 below trigger idle", tx, 1);
    for (int k = 0; k < 3; k++) wr_byte(8'(8'h51 + k));
    @(negedge clk);
    chk(tx == 0, "R6 trigger reached", tx, 0);
    drain(2000);
    chk(q.size() == 0 && tx == 1, "R10 drained below trigger", tx, 1);
    // FIFO trigger 0 means 16; fill and overflow
    trig = 4'd0; tx_en = 0; len7 = 1; msb = 0;
    for (int k = 0; k < 17; k++) wr_byte(8'(k * 13 + 7));
    chk(ovf == 1, "R9 seventeenth dropped", ovf, 1);
    @(negedge clk); tx_en = 1;
    // hammer writes while a full queue drains: some land on a load cycle
    wr = 1;
    for (int k = 0; k < 200; k++) begin wdata = 8'(k); @(negedge clk); end
    wr = 0;
    drain(3000);
    // tx_en dropped mid burst
    trig = 4'd2; len7 = 0; msb = 0;
    for (int k = 0; k < 5; k++) wr_byte(8'(8'hE0 + k));
    repeat (50) @(negedge clk);
    tx_en = 0;
    repeat (120) @(negedge clk);
    chk(tx == 1 && q.size() > 0, "R10 enable low stops loads", tx, 1);
    tx_en = 1;
    drain(2000);
    // single mode after fifo: no empty pulse
    fifo_mode = 0;
    wr_byte(8'h5A);
    drain(400);
    chk(empty_int == 0, "R8 no empty in single", empty_int, 0);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule